// File: doc/BRIEF.md
# Cascadable Registered Signed Multiplier

This block is a signed multiplier slice. It takes two 18-bit two's complement operands and returns their exact 36-bit two's complement product. The first operand always comes from a local port. The second operand comes from one of two sources, chosen by a parameter: a local port, or a chain input that a neighbouring slice drives. The slice forwards the second operand it selected on a chain output, so that several slices can share one operand along a row.

The operand A path, the operand B path and the product path can each have a pipeline register, and parameters set which of the three are present. A stage without a register passes its value straight through. Every present register has its own load enable and its own synchronous clear, and the clear takes priority over the enable. Parameters can invert the polarity of the clock and of each of the six control pins. All registers power up holding zero.

Top module: `smul_slice`

## Requirements
- R1: `p_out` is the exact signed product of the two operands that reach the multiplier, sign-extended to 36 bits with no truncation or saturation. For example, -131072 × -131072 gives 17179869184 and 131071 × -131072 gives -17179738112.
- R2: With `B_SRC` = `BSRC_LOCAL` (encoding 0) the B operand is taken from `b_in`. With `B_SRC` = `BSRC_CHAIN` (encoding 1) it is taken from `bc_in`, and the port that is not selected has no effect.
- R3: `bc_out` carries the B operand that feeds the multiplier. Without the B register it follows the selected source combinationally. With the B register it is that register's content.
- R4: A present register loads its input on the active clock edge when its enable is active and its clear is inactive. When the enable is inactive, it holds its value.
- R5: A present register becomes zero on any active clock edge where its clear is active, whatever the state of its enable.
- R6: Each of `USE_AREG`, `USE_BREG` and `USE_PREG` adds one register to its path when set to 1. When set to 0, that path is combinational. The latency from an operand to `p_out` is therefore the number of registers present on that path. With only one input register present, `p_out` also reacts at once to changes on the unregistered operand.
- R7: `INV_CLK` = 1 makes the falling edge of `clk` the active edge. Each of `INV_CE_A`, `INV_RST_A`, `INV_CE_B`, `INV_RST_B`, `INV_CE_P` and `INV_RST_P` = 1 makes its control pin active low.
- R8: Every present register holds zero before the first active clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the active edge is set by `INV_CLK` |
| a_in | input | 18 | Operand A, signed |
| b_in | input | 18 | Local operand B, signed |
| bc_in | input | 18 | Chain operand B from a neighbouring slice, signed |
| ce_a | input | 1 | Load enable for the A register |
| rst_a | input | 1 | Synchronous clear for the A register |
| ce_b | input | 1 | Load enable for the B register |
| rst_b | input | 1 | Synchronous clear for the B register |
| ce_p | input | 1 | Load enable for the product register |
| rst_p | input | 1 | Synchronous clear for the product register |
| p_out | output | 36 | Signed product |
| bc_out | output | 18 | Selected B operand forwarded to the next slice |

## Verification
On every cycle, the assertions check three things. Each present register loads, holds or clears exactly as its decoded enable and clear require. The product's sign and non-zero value agree with its two operands. Only the bench's scenarios can show the rest: that each of the sixteen combinations of register presence and B source gives the right latency and combinational paths, that the unselected B port has no effect, that the exact corner products come out right, that the inverted clock and control polarities behave as configured, and that the registers start at zero.

// File: rtl/smul_pkg.sv
package smul_pkg;

    localparam int OP_W   = 18;
    localparam int PROD_W = 2 * OP_W;

    typedef logic signed [OP_W-1:0]   opnd_t;
    typedef logic signed [PROD_W-1:0] prod_t;

    typedef enum logic {
        BSRC_LOCAL = 1'b0,
        BSRC_CHAIN = 1'b1
    } bsrc_e;

    // Decoded (active-high) controls of one pipeline register.
    typedef struct packed {
        logic load;
        logic clear;
    } regctl_t;

    function automatic regctl_t decode_ctl(input logic en_pin, input logic clr_pin,
                                           input bit inv_en, input bit inv_clr);
        regctl_t c;
        c.load  = en_pin ^ inv_en;
        c.clear = clr_pin ^ inv_clr;
        return c;
    endfunction

    // Full-width signed product: both operands sign-extended first.
    function automatic prod_t signed_mul(input opnd_t a, input opnd_t b);
        prod_t ax;
        prod_t bx;
        ax = prod_t'(a);
        bx = prod_t'(b);
        return ax * bx;
    endfunction

endpackage

// File: rtl/smul_pipe_reg.sv
module smul_pipe_reg
    import smul_pkg::*;
#(
    parameter int W       = 18,
    parameter bit PRESENT = 1'b1
) (
    input  logic          clk,
    input  regctl_t       ctl,
    input  logic [W-1:0]  d,
    output logic [W-1:0]  q
);

    generate
        if (PRESENT) begin : g_reg
            logic [W-1:0] stage_q = '0;

            always_ff @(posedge clk) begin
                if (ctl.clear)
                    stage_q <= '0;
                else if (ctl.load)
                    stage_q <= d;
            end

            assign q = stage_q;

            AST_CLEAR_WINS: assert property (@(posedge clk)
                ctl.clear |=> (stage_q == '0));  // R5
            AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (ctl.clear)
                ctl.load |=> (stage_q == $past(d)));  // R4
            AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (ctl.clear)
                !ctl.load |=> $stable(stage_q));  // R4
        end else begin : g_wire
            logic unused_ctl;
            assign unused_ctl = ^{clk, ctl};
            assign q = d;
        end
    endgenerate

endmodule

// File: rtl/smul_mult.sv
module smul_mult
    import smul_pkg::*;
(
    input  opnd_t a,
    input  opnd_t b,
    output prod_t p
);

    always_comb begin
        p = signed_mul(a, b);
    end

endmodule

// File: rtl/smul_slice.sv
module smul_slice
    import smul_pkg::*;
#(
    parameter bit    USE_AREG  = 1'b1,
    parameter bit    USE_BREG  = 1'b1,
    parameter bit    USE_PREG  = 1'b1,
    parameter bsrc_e B_SRC     = BSRC_LOCAL,
    parameter bit    INV_CLK   = 1'b0,
    parameter bit    INV_CE_A  = 1'b0,
    parameter bit    INV_RST_A = 1'b0,
    parameter bit    INV_CE_B  = 1'b0,
    parameter bit    INV_RST_B = 1'b0,
    parameter bit    INV_CE_P  = 1'b0,
    parameter bit    INV_RST_P = 1'b0
) (
    input  logic                     clk,
    input  logic signed [OP_W-1:0]   a_in,
    input  logic signed [OP_W-1:0]   b_in,
    input  logic signed [OP_W-1:0]   bc_in,
    input  logic                     ce_a,
    input  logic                     rst_a,
    input  logic                     ce_b,
    input  logic                     rst_b,
    input  logic                     ce_p,
    input  logic                     rst_p,
    output logic signed [PROD_W-1:0] p_out,
    output logic signed [OP_W-1:0]   bc_out
);

    localparam int MSB = OP_W - 1;

    logic    act_clk;
    regctl_t ctl_a;
    regctl_t ctl_b;
    regctl_t ctl_p;
    opnd_t   b_pick;
    opnd_t   a_op;
    opnd_t   b_op;
    prod_t   prod;

    assign act_clk = clk ^ INV_CLK;
    assign ctl_a   = decode_ctl(ce_a, rst_a, INV_CE_A, INV_RST_A);
    assign ctl_b   = decode_ctl(ce_b, rst_b, INV_CE_B, INV_RST_B);
    assign ctl_p   = decode_ctl(ce_p, rst_p, INV_CE_P, INV_RST_P);

    generate
        if (B_SRC == BSRC_CHAIN) begin : g_bchain
            logic unused_local;
            assign unused_local = ^b_in;
            assign b_pick = bc_in;
        end else begin : g_blocal
            logic unused_chain;
            assign unused_chain = ^bc_in;
            assign b_pick = b_in;
        end
    endgenerate

    smul_pipe_reg #(.W(OP_W), .PRESENT(USE_AREG)) u_areg (
        .clk (act_clk), .ctl (ctl_a), .d (a_in), .q (a_op)
    );

    smul_pipe_reg #(.W(OP_W), .PRESENT(USE_BREG)) u_breg (
        .clk (act_clk), .ctl (ctl_b), .d (b_pick), .q (b_op)
    );

    smul_mult u_mult (
        .a (a_op), .b (b_op), .p (prod)
    );

    smul_pipe_reg #(.W(PROD_W), .PRESENT(USE_PREG)) u_preg (
        .clk (act_clk), .ctl (ctl_p), .d (prod), .q (p_out)
    );

    assign bc_out = b_op;

    AST_SIGN_RULE: assert property (@(posedge act_clk) disable iff (ctl_p.clear)
        ((a_op != '0) && (b_op != '0)) |->
            ((prod != '0) && (prod[PROD_W-1] == (a_op[MSB] ^ b_op[MSB]))));  // R1

endmodule

// File: tb/test_smul_slice.sv
module test_smul_slice;
    import smul_pkg::*;

    localparam int NINST = 17;
    localparam int INV   = 16;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic signed [17:0] a_in = '0, b_in = '0, bc_in = '0;
    logic ce_a = 1'b1, rst_a = 1'b0, ce_b = 1'b1, rst_b = 1'b0, ce_p = 1'b1, rst_p = 1'b0;

    logic signed [35:0] p_o  [NINST];
    logic signed [17:0] bc_o [NINST];

    for (genvar g = 0; g < 16; g++) begin : g_dut
        smul_slice #(
            .USE_AREG (((g >> 0) & 1) == 1),
            .USE_BREG (((g >> 1) & 1) == 1),
            .USE_PREG (((g >> 2) & 1) == 1),
            .B_SRC    ((((g >> 3) & 1) == 1) ? BSRC_CHAIN : BSRC_LOCAL)
        ) i_smul_slice (
            .clk(clk), .a_in(a_in), .b_in(b_in), .bc_in(bc_in),
            .ce_a(ce_a), .rst_a(rst_a), .ce_b(ce_b), .rst_b(rst_b),
            .ce_p(ce_p), .rst_p(rst_p), .p_out(p_o[g]), .bc_out(bc_o[g])
        );
    end

    smul_slice #(
        .USE_AREG(1'b1), .USE_BREG(1'b1), .USE_PREG(1'b1), .B_SRC(BSRC_CHAIN),
        .INV_CLK(1'b1), .INV_CE_A(1'b1), .INV_RST_A(1'b1), .INV_CE_B(1'b1),
        .INV_RST_B(1'b1), .INV_CE_P(1'b1), .INV_RST_P(1'b1)
    ) i_smul_slice_inv (
        .clk(clk), .a_in(a_in), .b_in(b_in), .bc_in(bc_in),
        .ce_a(ce_a), .rst_a(rst_a), .ce_b(ce_b), .rst_b(rst_b),
        .ce_p(ce_p), .rst_p(rst_p), .p_out(p_o[INV]), .bc_out(bc_o[INV])
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    longint ma [NINST];
    longint mb [NINST];
    longint mp [NINST];

    function automatic bit has_a(int i); return (i == INV) ? 1'b1 : ((i & 1) != 0); endfunction
    function automatic bit has_b(int i); return (i == INV) ? 1'b1 : ((i & 2) != 0); endfunction
    function automatic bit has_p(int i); return (i == INV) ? 1'b1 : ((i & 4) != 0); endfunction
    function automatic bit chain(int i); return (i == INV) ? 1'b1 : ((i & 8) != 0); endfunction

    function automatic longint exp_a(int i);
        return has_a(i) ? ma[i] : longint'(a_in);
    endfunction
    function automatic longint exp_b(int i);
        longint sel;
        sel = chain(i) ? longint'(bc_in) : longint'(b_in);
        return has_b(i) ? mb[i] : sel;
    endfunction
    function automatic longint exp_p(int i);
        return has_p(i) ? mp[i] : exp_a(i) * exp_b(i);
    endfunction

    task automatic model_edge(int i, bit la, bit ca, bit lb, bit cb, bit lp, bit cp);
        longint np, nb;
        np = exp_a(i) * exp_b(i);
        nb = chain(i) ? longint'(bc_in) : longint'(b_in);
        if (ca) ma[i] = 0; else if (la) ma[i] = longint'(a_in);
        if (cb) mb[i] = 0; else if (lb) mb[i] = nb;
        if (cp) mp[i] = 0; else if (lp) mp[i] = np;
    endtask

    task automatic chk(string tag, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic check_all(string phase);
        for (int i = 0; i < NINST; i++) begin
            if (i == INV) begin
                chk($sformatf("%s R7 inverted product", phase), longint'(p_o[i]), exp_p(i));
                chk($sformatf("%s R7 inverted cascade", phase), longint'(bc_o[i]), exp_b(i));
            end else begin
                chk($sformatf("%s R1 R6 product cfg%0d", phase, i), longint'(p_o[i]), exp_p(i));
                chk($sformatf("%s R2 R3 cascade cfg%0d", phase, i), longint'(bc_o[i]), exp_b(i));
            end
        end
    endtask

    // Called just after a rising edge; ends just after the next rising edge.
    task automatic cyc(string phase);
        @(negedge clk);
        model_edge(INV, !ce_a, !rst_a, !ce_b, !rst_b, !ce_p, !rst_p);
        #1;
        check_all(phase);
        @(posedge clk);
        for (int i = 0; i < 16; i++) model_edge(i, ce_a, rst_a, ce_b, rst_b, ce_p, rst_p);
        #1;
    endtask

    task automatic set_ops(longint a, longint b, longint bc);
        a_in = 18'(a); b_in = 18'(b); bc_in = 18'(bc);
    endtask

    task automatic set_ctl(bit ea, bit ra, bit eb, bit rb, bit ep, bit rp);
        ce_a = ea; rst_a = ra; ce_b = eb; rst_b = rb; ce_p = ep; rst_p = rp;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = 32'h5EED_0042;
        void'($urandom(seed));
        for (int i = 0; i < NINST; i++) begin ma[i] = 0; mb[i] = 0; mp[i] = 0; end
        set_ops(1234, -777, 4321);
        #1;
        check_all("R8 powerup");
        chk("R8 powerup zero full pipe", longint'(p_o[7]), 0);
        @(posedge clk);
        for (int i = 0; i < 16; i++) model_edge(i, ce_a, rst_a, ce_b, rst_b, ce_p, rst_p);
        #1;

        // Random operands and controls
        for (int k = 0; k < 400; k++) begin
            set_ops(longint'($signed(18'($urandom))), longint'($signed(18'($urandom))),
                    longint'($signed(18'($urandom))));
            set_ctl(($urandom % 4) != 0, ($urandom % 10) == 0, ($urandom % 4) != 0,
                    ($urandom % 10) == 0, ($urandom % 4) != 0, ($urandom % 10) == 0);
            cyc("R4 R5 random");
        end

        // Corner: most negative squared
        set_ctl(1, 0, 1, 0, 1, 0);
        set_ops(-131072, -131072, -131072);
        cyc("R1 corner"); cyc("R1 corner"); cyc("R1 corner");
        chk("R1 min times min", longint'(p_o[7]), 64'sd17179869184);
        chk("R1 min times min chain", longint'(p_o[15]), 64'sd17179869184);

        // Corner: max positive times most negative
        set_ops(131071, -131072, -131072);
        cyc("R1 corner"); cyc("R1 corner"); cyc("R1 corner");
        chk("R1 max times min", longint'(p_o[7]), -64'sd17179738112);
        chk("R1 max times min comb", longint'(p_o[0]), -64'sd17179738112);

        // Unselected B port ignored, B register hold
        set_ctl(1, 0, 0, 0, 1, 0);
        set_ops(131071, 5, 9);
        cyc("R4 hold");
        chk("R4 B held on cascade", longint'(bc_o[7]), -131072);
        set_ctl(1, 0, 1, 0, 1, 0);
        set_ops(3, 11, -9);
        cyc("R2 source"); cyc("R2 source");
        chk("R2 local source ignores chain", longint'(bc_o[2]), 11);
        chk("R2 chain source ignores local", longint'(bc_o[10]), -9);
        chk("R3 comb cascade follows chain", longint'(bc_o[8]), -9);

        // Clear overrides enable
        set_ctl(1, 1, 1, 1, 1, 1);
        cyc("R5 clear");
        cyc("R5 clear");
        chk("R5 B cleared", longint'(bc_o[7]), 0);
        chk("R5 product cleared", longint'(p_o[7]), 0);

        // Inverted controls: pins low means load, clear inactive
        set_ctl(0, 1, 0, 1, 0, 1);
        set_ops(-100, 7, 250);
        cyc("R7 inv"); cyc("R7 inv"); cyc("R7 inv");
        chk("R7 inverted full pipe product", longint'(p_o[INV]), -25000);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule